// File: doc/BRIEF.md
# Serial EEPROM I2C Target Controller

This block is the two-wire bus front end of a byte-wide non-volatile memory. It oversamples SCL and SDA with a fast system clock and finds START and STOP conditions. It claims a transfer when the slave address carries the fixed memory type code 1010 and matches three strap inputs. It then takes a two-byte memory address and serves random, current-address and sequential reads. Write data goes into a page buffer. A STOP that follows a whole data byte commits the buffered bytes to the array and starts a timed write cycle. While that cycle runs, the device does not answer its own address, so a controller can poll for completion.

The array depth is `2**ADDR_W` bytes. `ADDR_W = 14` gives the full 16384-byte part, and the default is a smaller instance. The page holds `2**PAGE_W` bytes, which is 64 by default. `WR_CYCLES` sets the length of the write cycle in system clocks; the default is 5 ms at 50 MHz. A write-protect input blocks every array update. SDA is open drain: the block only asserts a pull-down enable.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) begins a transfer and a STOP (SDA rising while SCL is high) ends it. Bus activity without a preceding START, or after a rejected address, gets no response until the next START, and the pull-down is off while idle.
- R2: In the first byte after START, bits 7..4 must be 1010 and bits 3..1 must equal `strap_i[2:0]`. Bit 0 selects read (1) or write (0). On any mismatch SDA stays released.
- R3: The block pulls SDA low during the ninth clock for a matching slave address, for each memory-address byte, and for each write data byte while write protect is low.
- R4: A read byte is shifted out MSB first and SDA is released in the ninth clock. If the controller drives SDA low there, the next byte follows. After a not-acknowledge, SDA stays released.
- R5: SDA is sampled on the SCL rising edge. The pull-down enable changes only after an SCL falling edge, or when it is released at START or STOP.
- R6: The memory address is sent as two bytes, high byte first. Address bits at and above `ADDR_W` are ignored.
- R7: During a page write the low `PAGE_W` address bits advance and wrap inside the page. Bytes beyond one page overwrite bytes buffered earlier.
- R8: The buffered bytes are committed only by a STOP that arrives in the first bit time after a data byte's acknowledge. A STOP inside a byte discards the buffer. A commit holds the block busy for `WR_CYCLES` clocks.
- R9: While busy, the slave address is not acknowledged.
- R10: With `wp_i` high, the slave address and both address bytes are still acknowledged. Data bytes get a not-acknowledge, the array does not change and no busy period starts.
- R11: A sequential read advances the full `ADDR_W`-bit address and rolls over from the top address to 0.
- R12: A current-address read starts at the address counter. After a read, the counter holds the last byte read plus one. After a write, it holds the byte after the last buffered byte, wrapped inside the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND of all drivers) |
| strap_i | input | 3 | Device select straps compared with address bits 3..1 |
| wp_i | input | 1 | Write protect, high blocks array updates |
| sda_oe_o | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
Two events can fall on the same clock at the end of a read acknowledge slot. The address counter advances to the next location, possibly rolling over from the top of the array to 0, and the next byte is fetched and its first bit driven. The bench provokes this with a sequential read that straddles the top address and checks every byte against its own shadow of what was written. A second case has the page-pointer wrap and the current-address handoff meet. A three-byte write ends exactly on a page boundary and is followed by a current-address read, which must start at the first byte of the same page.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_RDATA
  } state_e;
endpackage

// File: rtl/eeprom_bus_sync.sv
module eeprom_bus_sync #(
  parameter int SYNC_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);
  logic [SYNC_W:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[SYNC_W-1:0], scl_i};
      sda_q <= {sda_q[SYNC_W-1:0], sda_i};
    end
  end

  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = scl_q[SYNC_W-1];
  assign scl_old = scl_q[SYNC_W];
  assign sda_now = sda_q[SYNC_W-1];
  assign sda_old = sda_q[SYNC_W];

  assign scl_rise_o = scl_now & ~scl_old;
  assign scl_fall_o = ~scl_now & scl_old;
  assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;
  assign sda_o      = sda_now;
endmodule

// File: rtl/eeprom_write_timer.sv
module eeprom_write_timer #(
  parameter int WR_CYCLES = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CNT_W'(WR_CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  assert_busy_after_commit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o);
  assert_busy_rise_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 6
) (
  input  logic                            clk_i,
  input  logic                            commit_i,
  input  logic [ADDR_W-PAGE_W-1:0]        page_i,
  input  logic [(1<<PAGE_W)-1:0][7:0]     buf_i,
  input  logic [(1<<PAGE_W)-1:0]          valid_i,
  input  logic [ADDR_W-1:0]               raddr_i,
  output logic [7:0]                      rdata_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (commit_i) begin
      for (int i = 0; i < PAGE_N; i++) begin
        if (valid_i[i]) mem_q[{page_i, PAGE_W'(i)}] <= buf_i[i];
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eeprom_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int PAGE_W    = 6,
  parameter int WR_CYCLES = 250000,
  parameter int SYNC_W    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int PG_W   = ADDR_W - PAGE_W;
  localparam int HI_W   = ADDR_W - 8;

  logic scl_rise, scl_fall, start_ev, stop_ev, sda_s;

  eeprom_bus_sync #(.SYNC_W(SYNC_W)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev), .sda_o(sda_s)
  );

  state_e                   st_q;
  logic [3:0]               cnt_q;
  logic                     ack_q, rw_q, mack_q, oe_q;
  logic [7:0]               rx_q;
  logic [6:0]               tx_q;
  logic [HI_W-1:0]          ahi_q;
  logic [ADDR_W-1:0]        addr_q;
  logic [PG_W-1:0]          page_q;
  logic [PAGE_W-1:0]        ptr_q;
  logic [PAGE_N-1:0][7:0]   pbuf_q;
  logic [PAGE_N-1:0]        pvld_q;
  logic                     busy, commit, dev_hit, ack_start;
  logic [7:0]               rdata;
  logic [ADDR_W-1:0]        new_addr;

  assign new_addr  = {ahi_q, rx_q};
  assign dev_hit   = (rx_q[7:4] == DEV_TYPE) && (rx_q[3:1] == strap_i) && !busy;
  assign ack_start = scl_fall && (cnt_q == 4'd8) && (st_q != ST_IDLE);
  // whole data bytes only: STOP lands in the bit time after the ack slot
  assign commit    = stop_ev && (st_q == ST_WDATA) && (cnt_q == 4'd1) && !ack_q
                     && (pvld_q != '0) && !wp_i;

  eeprom_write_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(commit), .busy_o(busy)
  );

  eeprom_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_array (
    .clk_i, .commit_i(commit), .page_i(page_q), .buf_i(pbuf_q),
    .valid_i(pvld_q), .raddr_i(addr_q), .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      ack_q  <= 1'b0;
      rw_q   <= 1'b0;
      mack_q <= 1'b0;
      oe_q   <= 1'b0;
      rx_q   <= '0;
      tx_q   <= '0;
      ahi_q  <= '0;
      addr_q <= '0;
      page_q <= '0;
      ptr_q  <= '0;
      pbuf_q <= '0;
      pvld_q <= '0;
    end else if (start_ev) begin
      st_q  <= ST_DEV;
      cnt_q <= '0;
      ack_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (stop_ev) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      ack_q  <= 1'b0;
      oe_q   <= 1'b0;
      pvld_q <= '0;
    end else if (st_q != ST_IDLE) begin
      if (scl_rise) begin
        cnt_q <= (cnt_q == 4'd8) ? 4'd0 : cnt_q + 4'd1;
        if (cnt_q != 4'd8) begin
          rx_q <= {rx_q[6:0], sda_s};
        end else if (st_q == ST_RDATA) begin
          mack_q <= ~sda_s;
          addr_q <= addr_q + 1'b1;
        end
      end else if (scl_fall) begin
        if (cnt_q == 4'd8) begin
          ack_q <= 1'b1;
          unique case (st_q)
            ST_DEV: begin
              if (dev_hit) begin
                oe_q <= 1'b1;
                rw_q <= rx_q[0];
              end else begin
                st_q <= ST_IDLE;
              end
            end
            ST_AHI: begin
              oe_q  <= 1'b1;
              ahi_q <= rx_q[HI_W-1:0];
            end
            ST_ALO: begin
              oe_q   <= 1'b1;
              addr_q <= new_addr;
              page_q <= new_addr[ADDR_W-1:PAGE_W];
              ptr_q  <= new_addr[PAGE_W-1:0];
              pvld_q <= '0;
            end
            ST_WDATA: begin
              if (!wp_i) begin
                oe_q           <= 1'b1;
                pbuf_q[ptr_q]  <= rx_q;
                pvld_q[ptr_q]  <= 1'b1;
                ptr_q          <= ptr_q + 1'b1;
                addr_q         <= {page_q, ptr_q + PAGE_W'(1)};
              end
            end
            default: oe_q <= 1'b0;
          endcase
        end else if (ack_q) begin
          ack_q <= 1'b0;
          oe_q  <= 1'b0;
          unique case (st_q)
            ST_DEV: begin
              if (rw_q) begin
                st_q <= ST_RDATA;
                tx_q <= rdata[6:0];
                oe_q <= ~rdata[7];
              end else begin
                st_q <= ST_AHI;
              end
            end
            ST_AHI: st_q <= ST_ALO;
            ST_ALO: st_q <= ST_WDATA;
            ST_RDATA: begin
              if (mack_q) begin
                tx_q <= rdata[6:0];
                oe_q <= ~rdata[7];
              end else begin
                st_q <= ST_IDLE;
              end
            end
            default: ;
          endcase
        end else if (st_q == ST_RDATA && cnt_q != 4'd0) begin
          oe_q <= ~tx_q[6];
          tx_q <= {tx_q[5:0], 1'b0};
        end
      end
    end
  end

  assign sda_oe_o = oe_q;

  assert_idle_silent_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !sda_oe_o);
  assert_read_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_start && st_q == ST_RDATA) |=> !sda_oe_o);
  assert_oe_after_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> $past(scl_fall || start_ev || stop_ev));
  assert_busy_nack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_start && st_q == ST_DEV && busy) |=> !sda_oe_o);
  assert_wp_data_nack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_start && st_q == ST_WDATA && wp_i) |=> !sda_oe_o);
  assert_no_commit_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> !busy);
endmodule

// File: tb/eeprom_i2c_slave_bench.sv
module eeprom_i2c_slave_bench;
  localparam int ADDR_W = 9;
  localparam int PAGE_W = 4;
  localparam int WR_CYC = 300;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic wp = 1'b0;
  logic oe;
  logic sda_line;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] model [512];

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~oe;

  eeprom_i2c_slave #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYC)) u_eeprom_i2c_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .strap_i(STRAP), .wp_i(wp), .sda_oe_o(oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    tick(5); m_sda = 1'b1; tick(5); m_scl = 1'b1;
    tick(6); m_sda = 1'b0; tick(6); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    tick(5); m_sda = 1'b0; tick(5); m_scl = 1'b1;
    tick(6); m_sda = 1'b1; tick(6);
  endtask

  task automatic send_bit(input logic b);
    tick(5); m_sda = b; tick(5); m_scl = 1'b1; tick(10); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    tick(5); m_sda = 1'b1; tick(5); m_scl = 1'b1; tick(5);
    ack = ~sda_line;
    tick(5); m_scl = 1'b0;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(5); m_sda = 1'b1; tick(5); m_scl = 1'b1; tick(5);
      b[i] = sda_line;
      tick(5); m_scl = 1'b0;
    end
    tick(5); m_sda = ~mack; tick(5); m_scl = 1'b1; tick(10); m_scl = 1'b0;
  endtask

  function automatic logic [7:0] dev(input logic [3:0] typ, input logic [2:0] s, input logic rw);
    return {typ, s, rw};
  endfunction

  task automatic poll_ready(output int nacks);
    logic a;
    nacks = 0;
    for (int k = 0; k < 60; k++) begin
      bus_start();
      send_byte(dev(4'hA, STRAP, 1'b0), a);
      bus_stop();
      if (a) break;
      nacks++;
    end
  endtask

  task automatic set_addr(input logic [8:0] a);
    logic ack;
    bus_start();
    send_byte(dev(4'hA, STRAP, 1'b0), ack); check("R3 dev ack", ack, 1);
    send_byte({7'h7F, a[8]}, ack);            check("R6 high addr ack", ack, 1);
    send_byte(a[7:0], ack);                   check("R3 low addr ack", ack, 1);
  endtask

  task automatic write_page(input logic [8:0] a, input int n, input int seed, input bit exp_busy);
    logic ack;
    logic [7:0] d;
    int nn;
    set_addr(a);
    for (int i = 0; i < n; i++) begin
      d = 8'(seed * 7 + i * 29 + 3);
      send_byte(d, ack);
      if (wp) check("R10 data nack", ack, 0);
      else begin
        check("R3 data ack", ack, 1);
        model[{a[8:4], 4'(a[3:0] + 4'(i))}] = d;
      end
    end
    bus_stop();
    poll_ready(nn);
    if (exp_busy) check("R9 busy nack", int'(nn > 0), 1);
    else          check("R10 no busy", nn, 0);
  endtask

  task automatic read_bytes(input logic [8:0] a, input int n, input string req);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      check(req, b, model[9'(a + 9'(i))]);
    end
    tick(6);
    check("R4 released after nack", sda_line, 1);
    bus_stop();
  endtask

  task automatic read_seq(input logic [8:0] a, input int n, input string req);
    logic ack;
    set_addr(a);
    bus_start();
    send_byte(dev(4'hA, STRAP, 1'b1), ack); check("R2 read dev ack", ack, 1);
    read_bytes(a, n, req);
  endtask

  task automatic read_cur(input logic [8:0] a, input int n);
    logic ack;
    bus_start();
    send_byte(dev(4'hA, STRAP, 1'b1), ack); check("R12 cur dev ack", ack, 1);
    read_bytes(a, n, "R12 current address");
  endtask

  initial begin
    logic ack;
    int nn;
    tick(5);
    check("R1 reset oe", oe, 0);
    rst_n = 1'b1;
    tick(5);

    // R1: matching address without START
    send_byte(dev(4'hA, STRAP, 1'b0), ack);
    check("R1 no start", ack, 0);

    // R2: strap sweep and type-code sweep
    for (int s = 0; s < 8; s++) begin
      bus_start();
      send_byte(dev(4'hA, 3'(s), 1'b0), ack);
      check("R2 strap", ack, int'(3'(s) == STRAP));
      if (3'(s) != STRAP) begin
        send_byte(dev(4'hA, STRAP, 1'b0), ack);
        check("R1 ignored after mismatch", ack, 0);
      end
      bus_stop();
    end
    for (int t = 0; t < 16; t++) begin
      bus_start();
      send_byte(dev(4'(t), STRAP, 1'(t & 1)), ack);
      check("R2 type code", ack, int'(t == 10));
      bus_stop();
    end

    // R7/R8/R9 page writes
    write_page(9'h000, 16, 1, 1'b1);
    write_page(9'h1F0, 16, 2, 1'b1);
    write_page(9'h035, 20, 3, 1'b1);

    read_seq(9'h000, 16, "R4 seq read");
    read_seq(9'h030, 16, "R7 page wrap");
    read_seq(9'h1FE, 4, "R11 rollover");
    read_cur(9'h002, 2);

    // R7/R12: write ending on page boundary, counter wraps to page start
    write_page(9'h03D, 3, 4, 1'b1);
    read_cur(9'h030, 3);

    // R10: write protect
    wp = 1'b1;
    write_page(9'h000, 4, 9, 1'b0);
    wp = 1'b0;
    read_seq(9'h000, 4, "R10 array unchanged");

    // R8: STOP inside a byte discards the buffer
    set_addr(9'h010);
    send_byte(8'h5A, ack); check("R3 data ack", ack, 1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_stop();
    poll_ready(nn);
    check("R8 partial no busy", nn, 0);
    read_seq(9'h010, 2, "R8 partial no write");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule